// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a synchronous DRAM device on every rising clock edge and works out which command the controller issued. It keeps a state for each of four banks (idle, row open, read burst, write burst). It holds the opened row of each bank, the column of the last accepted read or write, and each bank's auto-precharge request. It sits beside a memory model or a bus monitor. It reports the decoded command one cycle after the edge that sampled it. When a command does not fit the state of its target bank, it raises a one-cycle illegal strobe and discards the command.

Clock-enable handling is built in. A low clock enable in the previous cycle suspends the clock, so the command is ignored and burst counters hold. The refresh encoding with clock enable falling enters self-refresh, and self-refresh lasts until clock enable rises together with a deselect or a no-operation. Bursts have a fixed length given by a parameter. A new read or write on any bank cuts short a burst that is already running.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: `cmd_o` shows, one cycle after the sampling edge, the command decoded from the pins (cs, ras, cas, we). The codes are: cs high = deselect 1; HHH = no-op 0; LHH = activate 2; HLH = read 3, or 12 with A10 high; HLL = write 4, or 13 with A10 high; LHL = precharge 5, or 6 with A10 high; HHL = burst stop 7; LLH = refresh 8 when clock enable stays high, or self-refresh entry 9 when it falls; LLL = mode set 11; self-refresh exit 10; suspended cycle 14.
- R2: An activate to an idle bank opens it (state 1) and latches A0..A11 as that bank's row. An activate to a bank that is not idle is illegal.
- R3: A read or write to an open bank puts it in state 2 (read) or 3 (write). It latches A0..A8 on `col_addr_o` and copies A10 to that bank's `auto_pre_o`. After BURST_LEN cycles the bank returns to state 1, or to state 0 if auto-precharge was set.
- R4: A read, write or burst stop whose target bank is idle is illegal.
- R5: A precharge with A10 low closes only its target bank, and acts as a no-op on an idle bank. With A10 high it closes all four banks.
- R6: A legal read or write ends any burst running on another bank. The same command on the bursting bank restarts the burst count.
- R7: Burst stop ends every running burst. The bank goes to state 1, or to state 0 if auto-precharge was set. On an open bank that is not bursting, burst stop has no effect.
- R8: Refresh is legal only when all banks are idle, and it leaves all banks idle.
- R9: Self-refresh entry is legal only with all banks idle, and it sets `self_ref_o`. While clock enable stays low, cycles decode as suspended. Clock enable rising with deselect or no-op gives exit (code 10) and clears `self_ref_o`. Any other command during self-refresh is illegal.
- R10: Mode set is legal only with all banks idle, bank address zero and A7..A11 zero.
- R11: An illegal command raises `illegal_o` for exactly one cycle and changes no bank state, row or column.
- R12: Reset puts every bank in idle, clears `self_ref_o` and `illegal_o`, and sets `cmd_o` to no-op.
- R13: When clock enable was low in the previous cycle outside self-refresh, the command is ignored and burst counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples the pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Row / column / option address |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | One-cycle illegal-command strobe |
| bank_state_o | output | 8 | Two bits per bank: 0 idle, 1 open, 2 read, 3 write |
| row_addr_o | output | 48 | Latched row, 12 bits per bank |
| col_addr_o | output | 9 | Column of the last accepted read or write |
| auto_pre_o | output | 4 | Auto-precharge request per bank |
| self_ref_o | output | 1 | Self-refresh in progress |

## Verification
The hardest case to reach is a burst that is frozen by a suspended clock partway through its count. The bench opens a bank, starts a read, and drops clock enable for two edges while presenting an activate that must be ignored. It then counts the remaining burst cycles to confirm that exactly the held edges were skipped. Bursts cut short across two banks, and a burst restart with a deliberately shortened check window, show that truncation and restart happen at the right edge.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    C_NOP      = 4'd0,
    C_DESEL    = 4'd1,
    C_ACT      = 4'd2,
    C_RD       = 4'd3,
    C_WR       = 4'd4,
    C_PRE      = 4'd5,
    C_PREA     = 4'd6,
    C_TERM     = 4'd7,
    C_REF      = 4'd8,
    C_SREF_IN  = 4'd9,
    C_SREF_OUT = 4'd10,
    C_MRS      = 4'd11,
    C_RDA      = 4'd12,
    C_WRA      = 4'd13,
    C_HOLD     = 4'd14
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE   = 2'd0,
    B_ACTIVE = 2'd1,
    B_READ   = 2'd2,
    B_WRITE  = 2'd3
  } bank_st_e;

  function automatic logic is_col_cmd(cmd_e c);
    return (c == C_RD) || (c == C_RDA) || (c == C_WR) || (c == C_WRA);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  input  logic cke_prev_i,
  input  logic self_ref_i,
  input  logic ap_bit_i,
  output cmd_e cmd_o
);

  cmd_e base;

  always_comb begin
    case ({ras_ni, cas_ni, we_ni})
      3'b111:  base = C_NOP;
      3'b011:  base = C_ACT;
      3'b101:  base = ap_bit_i ? C_RDA : C_RD;
      3'b100:  base = ap_bit_i ? C_WRA : C_WR;
      3'b010:  base = ap_bit_i ? C_PREA : C_PRE;
      3'b110:  base = C_TERM;
      3'b001:  base = cke_i ? C_REF : C_SREF_IN;
      default: base = C_MRS;
    endcase

    if (self_ref_i) begin
      if (!cke_i)                      cmd_o = C_HOLD;
      else if (cs_ni || base == C_NOP) cmd_o = C_SREF_OUT;
      else                             cmd_o = base;
    end else if (!cke_prev_i) begin
      cmd_o = C_HOLD;
    end else if (cs_ni) begin
      cmd_o = C_DESEL;
    end else begin
      cmd_o = base;
    end
  end

endmodule

// File: rtl/sdram_cke_track.sv
module sdram_cke_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic enter_i,
  input  logic exit_i,
  output logic cke_prev_o,
  output logic self_ref_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_prev_o <= 1'b1;
      self_ref_o <= 1'b0;
    end else begin
      cke_prev_o <= cke_i;
      if (enter_i)     self_ref_o <= 1'b1;
      else if (exit_i) self_ref_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             sel_i,
  input  cmd_e             cmd_i,
  input  logic [ROW_W-1:0] row_i,
  output bank_st_e         state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ap_o
);

  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             ap_q, ap_d;
  logic             busy;
  bank_st_e         end_st;

  assign busy   = (st_q == B_READ) || (st_q == B_WRITE);
  assign end_st = ap_q ? B_IDLE : B_ACTIVE;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    row_d = row_q;
    ap_d  = ap_q;

    // natural burst countdown
    if (busy && adv_i) begin
      if (cnt_q == '0) begin
        st_d = end_st;
        ap_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    case (cmd_i)
      C_ACT: if (sel_i) begin
        st_d  = B_ACTIVE;
        row_d = row_i;
      end
      C_RD, C_RDA, C_WR, C_WRA: begin
        if (sel_i) begin
          st_d  = ((cmd_i == C_RD) || (cmd_i == C_RDA)) ? B_READ : B_WRITE;
          ap_d  = (cmd_i == C_RDA) || (cmd_i == C_WRA);
          cnt_d = CNT_LOAD;
        end else if (busy) begin
          st_d = end_st;
          ap_d = 1'b0;
        end
      end
      C_PRE: if (sel_i) begin
        st_d = B_IDLE;
        ap_d = 1'b0;
      end
      C_PREA, C_REF: begin
        st_d = B_IDLE;
        ap_d = 1'b0;
      end
      C_TERM: if (busy) begin
        st_d = end_st;
        ap_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      row_q <= '0;
      ap_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
      ap_q  <= ap_d;
    end
  end

  assign state_o = st_q;
  assign row_o   = row_q;
  assign ap_o    = ap_q;

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int MODE_W    = 7,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  input  logic                  we_ni,
  input  logic                  cke_i,
  input  logic [BA_W-1:0]       ba_i,
  input  logic [ROW_W-1:0]      addr_i,
  output logic [3:0]            cmd_o,
  output logic                  illegal_o,
  output logic [2*(2**BA_W)-1:0] bank_state_o,
  output logic [(2**BA_W)*ROW_W-1:0] row_addr_o,
  output logic [COL_W-1:0]      col_addr_o,
  output logic [(2**BA_W)-1:0]  auto_pre_o,
  output logic                  self_ref_o
);

  localparam int NB = 2 ** BA_W;

  logic     cke_prev, self_ref;
  cmd_e     cmd, cmd_eff, cmd_q;
  logic     ill, ill_q;
  logic     all_idle, mrs_fields_ok, adv;
  bank_st_e st [NB];
  bank_st_e tgt_st;
  logic [COL_W-1:0] col_q;

  sdram_cmd_decode u_dec (
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .cke_i      (cke_i),
    .cke_prev_i (cke_prev),
    .self_ref_i (self_ref),
    .ap_bit_i   (addr_i[AP_BIT]),
    .cmd_o      (cmd)
  );

  sdram_cke_track u_cke (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .enter_i    (cmd == C_SREF_IN && !ill),
    .exit_i     (cmd == C_SREF_OUT),
    .cke_prev_o (cke_prev),
    .self_ref_o (self_ref)
  );

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (st[b] != B_IDLE) all_idle = 1'b0;
    end
  end

  assign tgt_st        = st[ba_i];
  assign mrs_fields_ok = (ba_i == '0) && (addr_i[ROW_W-1:MODE_W] == '0);

  always_comb begin
    ill = 1'b0;
    if (self_ref && !(cmd == C_HOLD || cmd == C_SREF_OUT)) begin
      ill = 1'b1;
    end else begin
      case (cmd)
        C_ACT:                    ill = (tgt_st != B_IDLE);
        C_RD, C_RDA, C_WR, C_WRA: ill = (tgt_st == B_IDLE);
        C_TERM:                   ill = (tgt_st == B_IDLE);
        C_REF, C_SREF_IN:         ill = !all_idle;
        C_MRS:                    ill = !all_idle || !mrs_fields_ok;
        default:                  ill = 1'b0;
      endcase
    end
  end

  assign cmd_eff = ill ? C_NOP : cmd;
  assign adv     = (cmd != C_HOLD);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_slot #(
      .ROW_W     (ROW_W),
      .BURST_LEN (BURST_LEN)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (adv),
      .sel_i   (ba_i == BA_W'(g)),
      .cmd_i   (cmd_eff),
      .row_i   (addr_i),
      .state_o (st[g]),
      .row_o   (row_addr_o[g*ROW_W +: ROW_W]),
      .ap_o    (auto_pre_o[g])
    );
    assign bank_state_o[2*g +: 2] = st[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= C_NOP;
      ill_q <= 1'b0;
      col_q <= '0;
    end else begin
      cmd_q <= cmd;
      ill_q <= ill;
      if (!ill && is_col_cmd(cmd)) col_q <= addr_i[COL_W-1:0];
    end
  end

  assign cmd_o      = cmd_q;
  assign illegal_o  = ill_q;
  assign col_addr_o = col_q;
  assign self_ref_o = self_ref;

endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk
  import sdram_trk_pkg::*;
#(
  parameter int BA_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [BA_W-1:0]        ba_i,
  input logic [3:0]             cmd_o,
  input logic                   illegal_o,
  input logic [2*(2**BA_W)-1:0] bank_state_o,
  input logic                   self_ref_o
);

  function automatic logic [1:0] st_at(logic [2*(2**BA_W)-1:0] v, logic [BA_W-1:0] i);
    return v[2*i +: 2];
  endfunction

  function automatic logic is_col(logic [3:0] c);
    return (c == C_RD) || (c == C_RDA) || (c == C_WR) || (c == C_WRA);
  endfunction

  p_act_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_ACT && !illegal_o) |-> st_at(bank_state_o, $past(ba_i)) == B_ACTIVE);

  p_col_bursts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_col(cmd_o) && !illegal_o) |-> st_at(bank_state_o, $past(ba_i)) inside {B_READ, B_WRITE});

  p_prea_all_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_PREA) |-> bank_state_o == '0);

  p_ref_all_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_REF && !illegal_o) |-> bank_state_o == '0);

  p_sref_enter_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(self_ref_o) |-> (cmd_o == C_SREF_IN && !illegal_o));

  p_sref_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_o |-> bank_state_o == '0);

  p_ill_kind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(cmd_o inside {C_NOP, C_DESEL, C_HOLD, C_SREF_OUT}));

  p_hold_frozen_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_HOLD) |-> ($stable(bank_state_o) && !illegal_o));

endmodule

bind sdram_cmd_tracker sdram_trk_chk #(.BA_W(BA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ba_i         (ba_i),
  .cmd_o        (cmd_o),
  .illegal_o    (illegal_o),
  .bank_state_o (bank_state_o),
  .self_ref_o   (self_ref_o)
);

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_o;
  logic        illegal_o;
  logic [7:0]  bank_state_o;
  logic [47:0] row_addr_o;
  logic [8:0]  col_addr_o;
  logic [3:0]  auto_pre_o;
  logic        self_ref_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .addr_i(addr), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .bank_state_o(bank_state_o), .row_addr_o(row_addr_o),
    .col_addr_o(col_addr_o), .auto_pre_o(auto_pre_o), .self_ref_o(self_ref_o)
  );

  // pins: cs, ras, cas, we
  localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1111, P_ACT = 4'b0011,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_PRE = 4'b0010,
                         P_TERM = 4'b0110, P_REF = 4'b0001, P_MRS = 4'b0000;
  localparam logic K1 = 1'b1;

  // {pins, cke, ba, addr, exp cmd, exp illegal, exp bank states}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {P_NOP,  K1, 2'd0, 12'h000, 4'd0,  1'b0, 8'h00},  // R1
    {P_DES,  K1, 2'd0, 12'h000, 4'd1,  1'b0, 8'h00},  // R1
    {P_RD,   K1, 2'd0, 12'h000, 4'd3,  1'b1, 8'h00},  // R4
    {P_TERM, K1, 2'd0, 12'h000, 4'd7,  1'b1, 8'h00},  // R4
    {P_PRE,  K1, 2'd1, 12'h000, 4'd5,  1'b0, 8'h00},  // R5
    {P_ACT,  K1, 2'd1, 12'hABC, 4'd2,  1'b0, 8'h04},  // R2
    {P_ACT,  K1, 2'd1, 12'h000, 4'd2,  1'b1, 8'h04},  // R2 R11
    {P_ACT,  K1, 2'd2, 12'h123, 4'd2,  1'b0, 8'h14},  // R2
    {P_REF,  K1, 2'd0, 12'h000, 4'd8,  1'b1, 8'h14},  // R8
    {P_MRS,  K1, 2'd0, 12'h023, 4'd11, 1'b1, 8'h14},  // R10
    {P_TERM, K1, 2'd1, 12'h000, 4'd7,  1'b0, 8'h14},  // R7
    {P_PRE,  K1, 2'd0, 12'h400, 4'd6,  1'b0, 8'h00},  // R5
    {P_MRS,  K1, 2'd0, 12'h0A3, 4'd11, 1'b1, 8'h00},  // R10
    {P_MRS,  K1, 2'd1, 12'h033, 4'd11, 1'b1, 8'h00},  // R10
    {P_MRS,  K1, 2'd0, 12'h033, 4'd11, 1'b0, 8'h00},  // R10
    {P_REF,  K1, 2'd0, 12'h000, 4'd8,  1'b0, 8'h00},  // R8
    {P_ACT,  K1, 2'd3, 12'h0FF, 4'd2,  1'b0, 8'h40},  // R2
    {P_PRE,  K1, 2'd3, 12'h000, 4'd5,  1'b0, 8'h00}   // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] p, input logic k, input logic [1:0] b, input logic [11:0] a);
    {cs_n, ras_n, cas_n, we_n} = p;
    cke  = k;
    ba   = b;
    addr = a;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] st(input int b);
    return bank_state_o[2*b +: 2];
  endfunction

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    chk("R12 states", bank_state_o, 0);
    chk("R12 cmd", cmd_o, 0);
    chk("R12 ill", illegal_o, 0);
    chk("R12 sref", self_ref_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31:28], VEC[i][27], VEC[i][26:25], VEC[i][24:13]);
      chk($sformatf("R1 vec%0d cmd", i), cmd_o, VEC[i][12:9]);
      chk($sformatf("R11 vec%0d ill", i), illegal_o, VEC[i][8]);
      chk($sformatf("R2 vec%0d states", i), bank_state_o, VEC[i][7:0]);
    end
    chk("R2 row bank1", row_addr_o[12 +: 12], 12'hABC);
    chk("R2 row bank2", row_addr_o[24 +: 12], 12'h123);
    chk("R2 row bank3", row_addr_o[36 +: 12], 12'h0FF);

    // R3 read burst, no auto-precharge
    drive(P_ACT, 1, 0, 12'h055);
    drive(P_RD, 1, 0, 12'h1A5);
    chk("R3 rd state", st(0), 2);
    chk("R3 col", col_addr_o, 9'h1A5);
    chk("R3 ap clear", auto_pre_o[0], 0);
    for (int i = 0; i < 3; i++) begin
      drive(P_NOP, 1, 0, 0);
      chk("R3 rd hold", st(0), 2);
    end
    drive(P_NOP, 1, 0, 0);
    chk("R3 rd end", st(0), 1);

    // R3 write with auto-precharge
    drive(P_WR, 1, 0, 12'h407);
    chk("R1 wra code", cmd_o, 13);
    chk("R3 wr state", st(0), 3);
    chk("R3 ap set", auto_pre_o[0], 1);
    chk("R3 wr col", col_addr_o, 9'h007);
    for (int i = 0; i < 3; i++) begin
      drive(P_NOP, 1, 0, 0);
      chk("R3 wr hold", st(0), 3);
    end
    drive(P_NOP, 1, 0, 0);
    chk("R3 wra closes", st(0), 0);

    // R6 cross-bank truncation and restart
    drive(P_ACT, 1, 0, 12'h001);
    drive(P_ACT, 1, 1, 12'h002);
    drive(P_RD, 1, 0, 12'h010);
    drive(P_NOP, 1, 0, 0);
    drive(P_RD, 1, 1, 12'h420);
    chk("R1 rda code", cmd_o, 12);
    chk("R6 other burst cut", st(0), 1);
    chk("R6 new burst", st(1), 2);
    drive(P_NOP, 1, 0, 0);
    drive(P_RD, 1, 1, 12'h021);
    for (int i = 0; i < 3; i++) begin
      drive(P_NOP, 1, 0, 0);
      chk("R6 restart count", st(1), 2);
    end
    drive(P_TERM, 1, 1, 0);
    chk("R7 term to open", st(1), 1);
    drive(P_RD, 1, 1, 12'h400);
    drive(P_TERM, 1, 1, 0);
    chk("R7 term with ap", st(1), 0);
    chk("R7 ap cleared", auto_pre_o[1], 0);

    // R13 clock suspend mid-burst
    drive(P_RD, 1, 0, 12'h033);
    drive(P_NOP, 0, 0, 0);
    chk("R13 cke falls cmd", cmd_o, 0);
    drive(P_ACT, 0, 3, 12'h111);
    chk("R13 hold code", cmd_o, 14);
    chk("R13 act ignored", st(3), 0);
    drive(P_ACT, 1, 3, 12'h111);
    chk("R13 hold after rise", cmd_o, 14);
    chk("R13 act ignored2", st(3), 0);
    drive(P_NOP, 1, 0, 0);
    drive(P_NOP, 1, 0, 0);
    chk("R13 burst frozen", st(0), 2);
    drive(P_NOP, 1, 0, 0);
    chk("R13 burst resumes", st(0), 1);

    // R9 entry refused with an open bank
    drive(P_REF, 0, 0, 0);
    chk("R9 entry cmd", cmd_o, 9);
    chk("R9 entry illegal", illegal_o, 1);
    chk("R9 no sref", self_ref_o, 0);
    drive(P_NOP, 1, 0, 0);
    chk("R11 strobe one cycle", illegal_o, 0);
    drive(P_PRE, 1, 0, 12'h400);
    chk("R5 prea", bank_state_o, 0);

    // R9 self-refresh
    drive(P_REF, 0, 0, 0);
    chk("R9 enter", self_ref_o, 1);
    chk("R9 enter legal", illegal_o, 0);
    drive(P_ACT, 0, 2, 0);
    chk("R9 hold code", cmd_o, 14);
    chk("R9 hold legal", illegal_o, 0);
    drive(P_ACT, 1, 2, 0);
    chk("R9 bad exit ill", illegal_o, 1);
    chk("R9 bad exit stays", self_ref_o, 1);
    chk("R9 bad exit bank", st(2), 0);
    drive(P_DES, 1, 0, 0);
    chk("R9 exit code", cmd_o, 10);
    chk("R9 exit", self_ref_o, 0);
    drive(P_NOP, 1, 0, 0);
    chk("R1 nop after exit", cmd_o, 0);
    drive(P_REF, 0, 0, 0);
    drive(P_NOP, 1, 0, 0);
    chk("R9 nop exit", cmd_o, 10);
    chk("R9 nop exit clr", self_ref_o, 0);

    // R12 reset mid-operation
    drive(P_ACT, 1, 2, 12'h777);
    chk("R2 open before reset", st(2), 1);
    rst_ni = 1'b0;
    #1;
    chk("R12 reset states", bank_state_o, 0);
    chk("R12 reset cmd", cmd_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule